// File: doc/BRIEF.md
# Converter Serial Output Port

This block is the transmit half of a serial read port that sits beside a 10-bit converter. The conversion logic hands it each finished result as a parallel word with a one-cycle valid pulse. An external controller reads the word back over two wires: a convert-start strobe that also arms the port, and a serial clock that it drives. The port sends the word as straight binary, most significant bit first, on a data line that is released to high impedance whenever no read is running.

A rising edge on the strobe arms the port and clears its bit counter. Each later rising edge of the serial clock presents the next bit. After the falling edge that ends the tenth bit, the port lets go of the line and disarms itself. Any further serial clock activity is then ignored until the strobe rises again. Both the strobe and the serial clock are asynchronous to the system clock. They pass through two-flop synchronisers, and the port acts on the edges it sees in the system clock domain. The serial clock may run continuously or only in bursts.

A read-busy output tells the conversion side that a read is running. A result that arrives during a read is held back and moved into the output register only when the read ends. The word being sent therefore never changes part way through, and a read that starts before a conversion ends returns the earlier result.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, `ser_oe` and `rd_busy` are low and `ser_dout` is released (high impedance).
- R2: Until the strobe `cnv_start` has risen, serial clock edges never raise `ser_oe`.
- R3: After arming, the k-th serial clock rising edge (k = 0 first) drives bit W-1-k of the output register on `ser_dout` and sets `ser_oe` high. The word is straight binary, MSB first.
- R4: `rd_busy` and `ser_oe` rise with the first bit and stay high until the falling edge that ends bit W (the 10th). They drop on that edge.
- R5: After W bits have gone, further serial clock edges leave `ser_oe` low. The output register is not consumed, so a re-armed read returns the same word again.
- R6: A strobe rising edge during a read ends that read at once (`ser_oe` low). The next rising serial clock edge starts again at the MSB.
- R7: A result presented with `res_valid` while no read is running is loaded, and the next read returns it.
- R8: A result presented during a read does not change the word being sent. It is loaded when the read ends, and the following read returns it.
- R9: If several results arrive during one read, the newest of them is loaded when the read ends.
- R10: With a free-running serial clock, a strobe edge between clock pulses arms the port. The next rising serial clock edge sends the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_start | input | 1 | Convert-start strobe; its rising edge arms the port (asynchronous) |
| ser_clk | input | 1 | External serial clock (asynchronous) |
| res_valid | input | 1 | One-cycle pulse: a new conversion result is on `res_word` |
| res_word | input | W | New conversion result, straight binary |
| ser_dout | output | 1 | Serial data, high impedance when not sending |
| ser_oe | output | 1 | High while `ser_dout` is driven |
| rd_busy | output | 1 | Read in progress; loads of new results are deferred |

## Verification
Several rules are checked on every cycle. The data line may only turn on when the port is armed. The line turns off after the last falling edge. A strobe edge clears the counter. The bit counter never passes W-1 while the line is driven. The driven bit only changes on a rising serial clock edge. The output register stays still while a read is busy. The bench's scenarios show the rest: the order of the bits on the line, which result a read returns when conversions land before, during or after it, the newest-wins rule for several deferred results, and arming under a continuously running serial clock.

// File: rtl/conv_sp_pkg.sv
package conv_sp_pkg;

  localparam int unsigned SP_WORD_W = 10;
  localparam int unsigned SP_SYNC_STAGES = 2;

  // Bit sent at position idx (0 = first on the line) of a word of the given width.
  function automatic logic msb_first_bit(input logic [31:0] word,
                                         input int unsigned width,
                                         input int unsigned idx);
    logic [31:0] shifted;
    shifted = word << idx;
    return shifted[width-1];
  endfunction

endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/cs_result_hold.sv
module cs_result_hold #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_word,
  input  logic         block,
  output logic [W-1:0] out_word,
  output logic         load_now
);
  logic         pend_q;
  logic [W-1:0] pend_word;

  assign load_now = !block && (res_valid || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      pend_q    <= 1'b0;
      pend_word <= '0;
    end else if (load_now) begin
      out_word <= res_valid ? res_word : pend_word;
      pend_q   <= 1'b0;
    end else if (res_valid) begin
      pend_word <= res_word;
      pend_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_shift_ctl.sv
module cs_shift_ctl
  import conv_sp_pkg::*;
#(
  parameter int unsigned W  = 10,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rise,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic [W-1:0]  out_word,
  output logic          bit_q,
  output logic          oe_q,
  output logic          armed_q,
  output logic [CW-1:0] cnt_q,
  output logic          bit_go,
  output logic          first_go,
  output logic          last_fall
);
  logic is_last;

  assign is_last   = (cnt_q == CW'(W-1));
  assign bit_go    = sclk_rise & armed_q & ~start_rise;
  assign first_go  = bit_go & ~oe_q;
  assign last_fall = sclk_fall & oe_q & is_last & ~start_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      oe_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_rise) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (bit_go) begin
        oe_q  <= 1'b1;
        bit_q <= msb_first_bit(32'(out_word), W, 32'(cnt_q));
      end
      if (sclk_fall && oe_q) begin
        if (is_last) begin
          oe_q    <= 1'b0;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_sp_pkg::*;
#(
  parameter int unsigned W      = SP_WORD_W,
  parameter int unsigned STAGES = SP_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv_start,
  input  logic         ser_clk,
  input  logic         res_valid,
  input  logic [W-1:0] res_word,
  output logic         ser_dout,
  output logic         ser_oe,
  output logic         rd_busy
);
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;

  logic          start_rise;
  logic          start_fall;
  logic          sclk_rise;
  logic          sclk_fall;
  logic [W-1:0]  out_word;
  logic          load_now;
  logic          read_live;
  logic          bit_q;
  logic          oe_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          bit_go;
  logic          first_go;
  logic          last_fall;
  logic          unused_ok;

  cs_sync_edge #(.STAGES(STAGES)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .din(cnv_start),
    .rise(start_rise), .fall(start_fall)
  );

  cs_sync_edge #(.STAGES(STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_clk),
    .rise(sclk_rise), .fall(sclk_fall)
  );

  // A read counts as live from the cycle its first bit is launched.
  assign read_live = oe_q | first_go;

  cs_result_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
    .block(read_live), .out_word(out_word), .load_now(load_now)
  );

  cs_shift_ctl #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .out_word(out_word),
    .bit_q(bit_q), .oe_q(oe_q), .armed_q(armed_q), .cnt_q(cnt_q),
    .bit_go(bit_go), .first_go(first_go), .last_fall(last_fall)
  );

  assign ser_oe    = oe_q;
  assign rd_busy   = oe_q;
  assign ser_dout  = oe_q ? bit_q : 1'bz;
  assign unused_ok = start_fall ^ load_now;
endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk #(
  parameter int unsigned W  = 10,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_rise,
  input logic          bit_go,
  input logic          last_fall,
  input logic          armed_q,
  input logic [CW-1:0] cnt_q,
  input logic          bit_q,
  input logic          ser_oe,
  input logic          rd_busy,
  input logic [W-1:0]  out_word
);
  // R2
  arm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !$rose(ser_oe));

  // R4
  stop_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fall |=> (!ser_oe && !rd_busy));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> (32'(cnt_q) < W));

  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (!ser_oe && armed_q && cnt_q == '0));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && !bit_go) |=> $stable(bit_q));

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(out_word));
endmodule

bind conv_serial_port conv_serial_port_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .bit_go(bit_go),
  .last_fall(last_fall), .armed_q(armed_q), .cnt_q(cnt_q), .bit_q(bit_q),
  .ser_oe(ser_oe), .rd_busy(rd_busy), .out_word(out_word)
);

// File: tb/conv_serial_port_test.sv
module conv_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv_start = 1'b0;
  logic         ser_clk = 1'b0;
  logic         res_valid = 1'b0;
  logic [W-1:0] res_word = '0;
  logic         ser_dout;
  logic         ser_oe;
  logic         rd_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .ser_clk(ser_clk),
    .res_valid(res_valid), .res_word(res_word), .ser_dout(ser_dout),
    .ser_oe(ser_oe), .rd_busy(rd_busy)
  );

  function automatic logic exp_bit(input logic [W-1:0] word, input int k);
    return logic'((word >> (W - 1 - k)) & 1);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    cnv_start = 1'b0;
    tick(4);
    cnv_start = 1'b1;
    tick(4);
  endtask

  task automatic give_result(input logic [W-1:0] w);
    res_valid = 1'b1;
    res_word  = w;
    tick(1);
    res_valid = 1'b0;
    tick(1);
  endtask

  // Read bits from..to-1 of the expected word, checking each one and the line state.
  task automatic read_range(input logic [W-1:0] w, input int from, input int upto,
                            input string req);
    for (int k = from; k < upto; k++) begin
      int ph;
      ph = 4 + int'($urandom_range(0, 3));
      ser_clk = 1'b1;
      tick(ph);
      chk(ser_oe === 1'b1 && rd_busy === 1'b1, req, {ser_oe, rd_busy}, 3);
      chk(ser_dout === exp_bit(w, k), req, int'(ser_dout), int'(exp_bit(w, k)));
      ser_clk = 1'b0;
      tick(ph);
      if (k == W - 1)
        chk(ser_oe === 1'b0 && rd_busy === 1'b0, "R4", {ser_oe, rd_busy}, 0);
      else
        chk(ser_oe === 1'b1, "R4", int'(ser_oe), 1);
    end
  endtask

  task automatic idle_pulses(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b1;
      tick(4);
      chk(ser_oe === 1'b0, req, int'(ser_oe), 0);
      ser_clk = 1'b0;
      tick(4);
      chk(ser_oe === 1'b0, req, int'(ser_oe), 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    logic [W-1:0] wa, wb, wc, wr;
    void'($urandom(32'h1F2E3D4C));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk(ser_oe === 1'b0 && rd_busy === 1'b0, "R1", {ser_oe, rd_busy}, 0);

    // R2 clocks before any arming edge
    idle_pulses(3, "R2");

    // R7, R3, R4 plain read of a fresh result
    wa = 10'h2A5;
    give_result(wa);
    arm();
    read_range(wa, 0, W, "R3");

    // R5 extra clocks ignored, re-arm gives the same word
    idle_pulses(3, "R5");
    arm();
    read_range(wa, 0, W, "R5");

    // R7 new result loaded while idle
    wb = 10'h3C1;
    give_result(wb);
    arm();
    read_range(wb, 0, W, "R7");

    // R8 result during a read is deferred
    wc = 10'h00F;
    arm();
    read_range(wb, 0, 4, "R8");
    give_result(wc);
    read_range(wb, 4, W, "R8");
    arm();
    read_range(wc, 0, W, "R8");

    // R9 two results during one read, newest wins
    wa = 10'h155;
    wb = 10'h2AA;
    arm();
    read_range(wc, 0, 3, "R9");
    give_result(wa);
    give_result(wb);
    read_range(wc, 3, W, "R9");
    arm();
    read_range(wb, 0, W, "R9");

    // R6 re-arm in the middle of a read
    wa = 10'h3FE;
    give_result(wa);
    arm();
    read_range(wa, 0, 3, "R6");
    arm();
    chk(ser_oe === 1'b0, "R6", int'(ser_oe), 0);
    read_range(wa, 0, W, "R6");

    // R10 continuous serial clock, strobe raised between pulses
    wb = 10'h201;
    give_result(wb);
    cnv_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ser_clk = 1'b1;
      tick(4);
      chk(ser_oe === 1'b0, "R10", int'(ser_oe), 0);
      ser_clk = 1'b0;
      tick(2);
      if (i == 2) cnv_start = 1'b1;
      tick(2);
    end
    read_range(wb, 0, W, "R10");

    // Random results and clock phases
    for (int it = 0; it < 15; it++) begin
      wr = W'($urandom_range(0, (1 << W) - 1));
      give_result(wr);
      arm();
      read_range(wr, 0, W, "R3");
      idle_pulses(int'($urandom_range(0, 2)), "R5");
    end

    // Directed extremes
    give_result('0);
    arm();
    read_range('0, 0, W, "R3");
    give_result('1);
    arm();
    read_range('1, 0, W, "R3");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule